// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block decides whether a pending interrupt should interrupt the processor. Software posts requests by writing a request register. Only a contiguous band of bit positions is kept from that write, and each of those positions stands for one software priority level. A separate vector of level-sensitive hardware lines enters the same space higher up, and each hardware line's bit position is also its priority level. A current-level register holds the level the processor is running at.

When the evaluate strobe is sampled high, the block takes a snapshot of the software requests, the hardware lines, the current level and the asynchronous-trap request input. On the following clock edge it resolves the highest pending level. When that level is non-zero and strictly above the snapshot of the current level, it issues a one-cycle trap pulse and loads two holding registers. The summary register receives every pending bit and the ID register receives the winning level. A non-zero asynchronous-trap request at evaluation time is not supported, so the block reports it on an error pulse with the same timing as the trap pulse.

Top module: `ipl_arbiter`

## Requirements
- R1: After reset, trap_o, err_o, summary_o, intid_o, cur_lvl_o and sw_req_o are all zero.
- R2: A write to the software request register keeps only bits 4 to 18 (mask 0x0007FFF0). The stored value reads back on sw_req_o after the write edge.
- R3: A write to the current-level register keeps only the low 5 bits of the write data. The stored value reads back on cur_lvl_o after the write edge.
- R4: A pending software request at bit i (4 to 18) has priority level i-3, so bit 4 is level 1 and bit 18 is level 15.
- R5: Hardware line k (0 to 11) occupies summary bit 20+k and has priority level 20+k.
- R6: On a trap, summary_o holds one bit set for every pending software and hardware request, with each request at its own bit position.
- R7: The winning level is the highest level among all pending requests, so any hardware line outranks any software request.
- R8: A trap is taken only when the winning level is non-zero and strictly greater than the current level. When no trap is taken, summary_o and intid_o keep their previous values.
- R9: When the strobe is sampled at edge k, trap_o is high for exactly the one cycle after edge k+1. No evaluation happens without a strobe.
- R10: A non-zero asynchronous-trap request sampled with the strobe raises err_o for the one cycle after edge k+1. With the request at zero, err_o stays low.
- R11: When a trap is taken, intid_o shows the winning level from the cycle of the trap pulse onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Write enable for the software request register |
| sw_wdata_i | input | 32 | Write data for the software request register |
| lvl_we_i | input | 1 | Write enable for the current-level register |
| lvl_wdata_i | input | 32 | Write data for the current-level register |
| hw_irq_i | input | 12 | Level-sensitive hardware interrupt lines |
| ast_req_i | input | 4 | Asynchronous-trap request value (unsupported when non-zero) |
| eval_i | input | 1 | Evaluate strobe |
| trap_o | output | 1 | One-cycle trap request pulse |
| err_o | output | 1 | One-cycle pulse flagging an unsupported asynchronous-trap request |
| summary_o | output | 32 | Bitmap of the requests pending at the last trap |
| intid_o | output | 5 | Winning level of the last trap |
| cur_lvl_o | output | 5 | Current-level register contents |
| sw_req_o | output | 32 | Software request register contents |

## Verification
The bench targets the places where the level arithmetic goes wrong. It drives software bit 4 and bit 18 alone and together. A design that mapped bit position straight to level would report 4 or 18 instead of 1 or 15. It also mixes the top software request with hardware lines 0 and 11, where a wrong remap or scan order would let software win or report the lowest line. At the comparison boundary it sets the current level equal to the pending level and then one below it. An off-by-one compare would trap on the equal case or miss the lower one. Further tests hold hardware lines high without a strobe, raise the asynchronous-trap request, and write all-ones to both registers. These catch a design that evaluates continuously, one that never reports the error, and one with a wrong write mask.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEVEL_W   = 5;
  localparam int unsigned SWB_LO    = 4;
  localparam int unsigned SWB_HI    = 18;
  localparam int unsigned HWB_LO    = 20;
  localparam int unsigned HW_LINES  = 12;
  localparam int unsigned ASTREQ_W  = 4;

  // Bit mask with ones from lo to hi inclusive.
  function automatic logic [WORD_W-1:0] band_mask(input int unsigned lo, input int unsigned hi);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ipl_rst_sync.sv
module ipl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ipl_sw_reg.sv
module ipl_sw_reg #(
  parameter int unsigned DATA_W = ipl_pkg::WORD_W,
  parameter int unsigned SW_LO  = ipl_pkg::SWB_LO,
  parameter int unsigned SW_HI  = ipl_pkg::SWB_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(ipl_pkg::band_mask(SW_LO, SW_HI));

  logic [DATA_W-1:0] req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (we_i) req_d = wdata_i & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign q_o = req_q;
endmodule

// File: rtl/ipl_level_reg.sv
module ipl_level_reg #(
  parameter int unsigned DATA_W = ipl_pkg::WORD_W,
  parameter int unsigned LVL_W  = ipl_pkg::LEVEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LVL_W-1:0]  q_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:LVL_W];

  always_comb begin
    lvl_d = lvl_q;
    if (we_i) lvl_d = wdata_i[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/ipl_scan.sv
module ipl_scan #(
  parameter int unsigned DATA_W = ipl_pkg::WORD_W,
  parameter int unsigned LVL_W  = ipl_pkg::LEVEL_W,
  parameter int unsigned SW_LO  = ipl_pkg::SWB_LO,
  parameter int unsigned SW_HI  = ipl_pkg::SWB_HI
) (
  input  logic [DATA_W-1:0] pend_i,
  output logic [LVL_W-1:0]  win_o
);
  logic [LVL_W-1:0] bit_lvl [DATA_W];

  // Per-position level: software band is rebased to start at 1,
  // every other position is its own level.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lvl
    if (g >= SW_LO && g <= SW_HI) begin : g_sw
      assign bit_lvl[g] = LVL_W'(g - SW_LO + 1);
    end else begin : g_direct
      assign bit_lvl[g] = LVL_W'(g);
    end
  end

  // Ascending scan, the last pending position found wins.
  always_comb begin
    win_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (pend_i[i]) win_o = bit_lvl[i];
    end
  end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
  parameter int unsigned DATA_W = ipl_pkg::WORD_W,
  parameter int unsigned LVL_W  = ipl_pkg::LEVEL_W,
  parameter int unsigned SW_LO  = ipl_pkg::SWB_LO,
  parameter int unsigned SW_HI  = ipl_pkg::SWB_HI,
  parameter int unsigned HW_LO  = ipl_pkg::HWB_LO,
  parameter int unsigned HW_N   = ipl_pkg::HW_LINES,
  parameter int unsigned AST_W  = ipl_pkg::ASTREQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              lvl_we_i,
  input  logic [DATA_W-1:0] lvl_wdata_i,
  input  logic [HW_N-1:0]   hw_irq_i,
  input  logic [AST_W-1:0]  ast_req_i,
  input  logic              eval_i,
  output logic              trap_o,
  output logic              err_o,
  output logic [DATA_W-1:0] summary_o,
  output logic [LVL_W-1:0]  intid_o,
  output logic [LVL_W-1:0]  cur_lvl_o,
  output logic [DATA_W-1:0] sw_req_o
);
  localparam int unsigned PAD_W = DATA_W - HW_N;

  logic              rst_ns;
  logic [DATA_W-1:0] sw_q;
  logic [LVL_W-1:0]  lvl_q;

  ipl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  ipl_sw_reg #(.DATA_W(DATA_W), .SW_LO(SW_LO), .SW_HI(SW_HI)) u_sw (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we_i    (sw_we_i),
    .wdata_i (sw_wdata_i),
    .q_o     (sw_q)
  );

  ipl_level_reg #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we_i    (lvl_we_i),
    .wdata_i (lvl_wdata_i),
    .q_o     (lvl_q)
  );

  // Snapshot stage, loaded on the strobe
  logic              eval_q;
  logic [DATA_W-1:0] sw_snap_q;
  logic [HW_N-1:0]   hw_snap_q;
  logic [LVL_W-1:0]  lvl_snap_q;
  logic [AST_W-1:0]  ast_snap_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      eval_q     <= 1'b0;
      sw_snap_q  <= '0;
      hw_snap_q  <= '0;
      lvl_snap_q <= '0;
      ast_snap_q <= '0;
    end else begin
      eval_q <= eval_i;
      if (eval_i) begin
        sw_snap_q  <= sw_q;
        hw_snap_q  <= hw_irq_i;
        lvl_snap_q <= lvl_q;
        ast_snap_q <= ast_req_i;
      end
    end
  end

  // Resolution
  logic [DATA_W-1:0] pend;
  logic [LVL_W-1:0]  win;
  logic              take;

  assign pend = sw_snap_q | ({{PAD_W{1'b0}}, hw_snap_q} << HW_LO);

  ipl_scan #(.DATA_W(DATA_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI)) u_scan (
    .pend_i (pend),
    .win_o  (win)
  );

  assign take = eval_q && (win != '0) && (win > lvl_snap_q);

  // Result stage
  logic              trap_q, trap_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] sum_q, sum_d;
  logic [LVL_W-1:0]  id_q, id_d;

  always_comb begin
    trap_d = take;
    err_d  = eval_q && (ast_snap_q != '0);
    sum_d  = sum_q;
    id_d   = id_q;
    if (take) begin
      sum_d = pend;
      id_d  = win;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      trap_q <= 1'b0;
      err_q  <= 1'b0;
      sum_q  <= '0;
      id_q   <= '0;
    end else begin
      trap_q <= trap_d;
      err_q  <= err_d;
      sum_q  <= sum_d;
      id_q   <= id_d;
    end
  end

  assign trap_o    = trap_q;
  assign err_o     = err_q;
  assign summary_o = sum_q;
  assign intid_o   = id_q;
  assign cur_lvl_o = lvl_q;
  assign sw_req_o  = sw_q;
endmodule

// File: rtl/ipl_arbiter_chk.sv
module ipl_arbiter_chk #(
  parameter int unsigned DATA_W = ipl_pkg::WORD_W,
  parameter int unsigned LVL_W  = ipl_pkg::LEVEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_i,
  input logic              trap_o,
  input logic              err_o,
  input logic [DATA_W-1:0] summary_o,
  input logic [LVL_W-1:0]  intid_o
);
  AST_TRAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(eval_i, 2)); // R9

  AST_ERR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(eval_i, 2)); // R10

  AST_TRAP_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (intid_o != '0)); // R8

  AST_TRAP_HAS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (summary_o != '0)); // R6

  AST_ID_HOLDS_WITHOUT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(intid_o)); // R8

  AST_SUMMARY_HOLDS_WITHOUT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(summary_o)); // R8
endmodule

bind ipl_arbiter ipl_arbiter_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eval_i    (eval_i),
  .trap_o    (trap_o),
  .err_o     (err_o),
  .summary_o (summary_o),
  .intid_o   (intid_o)
);

// File: tb/tb_ipl_arbiter.sv
module tb_ipl_arbiter;
  logic        clk;
  logic        rst_n;
  logic        sw_we_i;
  logic [31:0] sw_wdata_i;
  logic        lvl_we_i;
  logic [31:0] lvl_wdata_i;
  logic [11:0] hw_irq_i;
  logic [3:0]  ast_req_i;
  logic        eval_i;
  logic        trap_o;
  logic        err_o;
  logic [31:0] summary_o;
  logic [4:0]  intid_o;
  logic [4:0]  cur_lvl_o;
  logic [31:0] sw_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ipl_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .lvl_we_i(lvl_we_i), .lvl_wdata_i(lvl_wdata_i),
    .hw_irq_i(hw_irq_i), .ast_req_i(ast_req_i), .eval_i(eval_i),
    .trap_o(trap_o), .err_o(err_o), .summary_o(summary_o),
    .intid_o(intid_o), .cur_lvl_o(cur_lvl_o), .sw_req_o(sw_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic write_sw(input logic [31:0] v);
    @(negedge clk); sw_we_i = 1'b1; sw_wdata_i = v;
    @(negedge clk); sw_we_i = 1'b0;
  endtask

  task automatic write_lvl(input logic [31:0] v);
    @(negedge clk); lvl_we_i = 1'b1; lvl_wdata_i = v;
    @(negedge clk); lvl_we_i = 1'b0;
  endtask

  // Strobe sampled at edge k; results sampled after edge k+1 and k+2.
  task automatic strobe(output logic t1, output logic e1, output logic [31:0] s1,
                        output logic [4:0] id1, output logic t2, output logic e2);
    @(negedge clk); eval_i = 1'b1;
    @(negedge clk); eval_i = 1'b0;
    @(negedge clk); t1 = trap_o; e1 = err_o; s1 = summary_o; id1 = intid_o;
    @(negedge clk); t2 = trap_o; e2 = err_o;
  endtask

  task automatic t_reset;
    check("R1", "trap", 32'(trap_o), 0);
    check("R1", "err", 32'(err_o), 0);
    check("R1", "summary", summary_o, 0);
    check("R1", "intid", 32'(intid_o), 0);
    check("R1", "cur_lvl", 32'(cur_lvl_o), 0);
    check("R1", "sw_req", sw_req_o, 0);
  endtask

  task automatic t_masks;
    write_sw(32'hFFFF_FFFF);
    check("R2", "sw mask all-ones", sw_req_o, 32'h0007_FFF0);
    write_sw(32'h0008_000F);
    check("R2", "sw mask outside band", sw_req_o, 32'h0);
    write_lvl(32'hFFFF_FFE7);
    check("R3", "level low 5 bits", 32'(cur_lvl_o), 32'h07);
    write_lvl(32'h0);
    write_sw(32'h0);
  endtask

  task automatic t_sw_levels;
    logic t1, e1, t2, e2; logic [31:0] s1; logic [4:0] id1;
    write_sw(32'h0000_0010);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R4", "bit4 trap", 32'(t1), 1);
    check("R4", "bit4 level", 32'(id1), 1);
    check("R9", "pulse single cycle", 32'(t2), 0);
    write_sw(32'h0004_0010);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R4", "bit18 level", 32'(id1), 15);
    check("R6", "sw summary", s1, 32'h0004_0010);
    check("R11", "intid held after pulse", 32'(intid_o), 15);
  endtask

  task automatic t_hw_mix;
    logic t1, e1, t2, e2; logic [31:0] s1; logic [4:0] id1;
    write_sw(32'h0004_0000);
    hw_irq_i = 12'h001;
    strobe(t1, e1, s1, id1, t2, e2);
    check("R7", "hw line0 beats sw bit18", 32'(id1), 20);
    check("R5", "hw line0 summary bit20", s1, 32'h0014_0000);
    hw_irq_i = 12'h801;
    strobe(t1, e1, s1, id1, t2, e2);
    check("R7", "line11 highest", 32'(id1), 31);
    check("R6", "all pending bits", s1, 32'h8014_0000);
    check("R9", "pulse single cycle hw", 32'(t2), 0);
    hw_irq_i = 12'h0;
  endtask

  task automatic t_compare;
    logic t1, e1, t2, e2; logic [31:0] s1; logic [4:0] id1;
    write_sw(32'h0000_0010);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R8", "setup trap", 32'(id1), 1);
    write_sw(32'h0004_0000);
    write_lvl(32'd15);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R8", "equal level no trap", 32'(t1), 0);
    check("R8", "intid unchanged", 32'(id1), 1);
    check("R8", "summary unchanged", s1, 32'h0000_0010);
    write_lvl(32'd14);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R8", "one above level traps", 32'(t1), 1);
    check("R8", "one above level id", 32'(id1), 15);
    write_lvl(32'd0);
    write_sw(32'h0);
    strobe(t1, e1, s1, id1, t2, e2);
    check("R8", "nothing pending no trap", 32'(t1), 0);
  endtask

  task automatic t_no_strobe;
    hw_irq_i = 12'h400;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", "no trap without strobe", 32'(trap_o), 0);
    end
    hw_irq_i = 12'h0;
  endtask

  task automatic t_ast;
    logic t1, e1, t2, e2; logic [31:0] s1; logic [4:0] id1;
    ast_req_i = 4'b0010;
    strobe(t1, e1, s1, id1, t2, e2);
    check("R10", "error raised", 32'(e1), 1);
    check("R10", "error one cycle", 32'(e2), 0);
    ast_req_i = 4'b0000;
    strobe(t1, e1, s1, id1, t2, e2);
    check("R10", "no error when zero", 32'(e1), 0);
  endtask

  initial begin
    rst_n = 1'b0; sw_we_i = 0; sw_wdata_i = 0; lvl_we_i = 0; lvl_wdata_i = 0;
    hw_irq_i = 0; ast_req_i = 0; eval_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_masks();
    t_sw_levels();
    t_hw_mix();
    t_compare();
    t_no_strobe();
    t_ast();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule